// File: doc/BRIEF.md
# Two-Tier Interrupt Aggregator

This block gathers interrupt requests for a small microcontroller-style core into a single request line and a vector address. It takes a timer overflow pulse, an external pin with a programmable active edge, a group of change-sensing inputs that share one flag, and a parameterised number of peripheral completion pulses. Each event latches a flag that stays set until software clears it with a write-one-to-clear access, so the handler can read the flag register to find out which sources are pending.

A flag reaches the core only through two or three gates. Core-class sources (timer, pin, change group) need their own enable bit and the global enable. Peripheral-class sources also need the peripheral-group enable. The request output is the OR of every fully gated flag. When the core takes an interrupt it pulses `irq_take_i`, which clears the global enable. A return strobe `irq_ret_i` sets the global enable again. The vector output presents the interrupt entry address while a request is active and the reset address otherwise.

Source bit layout: bit 0 is the timer overflow, bit 1 is the external pin, bit 2 is the change group, and bits 3 and up are peripherals 0, 1 and so on. Register selects: 0 is the flag register (write one to clear), 1 is the enable register, and 2 is control. Control bits: bit 0 is the global enable, bit 1 is the peripheral-group enable, and bit 2 is the edge select (1 for rising, 0 for falling).

Top module: `irq_agg_top`

## Requirements
- R1: After reset, `flag_o` and `ien_o` are all zero, `ctrl_o` is 3'b100 (global and peripheral-group enables off, rising edge selected), `irq_o` is 0 and `vec_o` is the reset address 0x000.
- R2: A core-class source (bits 0 to 2) drives `irq_o` high exactly when its flag bit, its enable bit and control bit 0 (global enable) are all 1.
- R3: A peripheral-class source (bit 3 and up) also needs control bit 1 (peripheral-group enable) to be 1 before it can drive `irq_o`.
- R4: A flag bit stays set until a write to select 0 has a 1 in that bit position. Zero bits in that write leave their flags unchanged. A flag that is still set raises `irq_o` again as soon as the global enable returns.
- R5: When a set event and a clear write hit the same flag in the same cycle, the flag ends up set.
- R6: With control bit 2 at 1, a rising edge on `ext_pin_i` sets flag bit 1 and a falling edge is ignored. With control bit 2 at 0, the reverse holds. The flag appears within SYNC_STAGES+2 cycles of the edge.
- R7: A change in any bit of `chg_in_i` sets the single shared flag bit 2.
- R8: `vec_o` equals the interrupt entry address 0x004 while `irq_o` is 1, and the reset address 0x000 while it is 0.
- R9: A pulse on `irq_take_i` clears the global enable at the next edge, and this wins over a return strobe or a control write in the same cycle. A pulse on `irq_ret_i` alone sets the global enable.
- R10: A one-cycle pulse on `tmr_ovf_i` sets flag bit 0 at the next edge. A one-cycle pulse on `periph_done_i[j]` sets flag bit 3+j at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| chg_in_i | input | CHG_W | Change-sensed input group, asynchronous |
| periph_done_i | input | NUM_PERIPH | Peripheral completion pulses |
| irq_take_i | input | 1 | Core has taken the interrupt |
| irq_ret_i | input | 1 | Return-from-interrupt strobe |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select |
| cfg_wdata_i | input | NUM_PERIPH+3 | Register write data |
| flag_o | output | NUM_PERIPH+3 | Pending flags, readable |
| ien_o | output | NUM_PERIPH+3 | Per-source enables, readable |
| ctrl_o | output | 3 | Edge select, peripheral-group enable, global enable |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | ADDR_W | Vector address |

## Verification
The bench builds the block with NUM_PERIPH=2, CHG_W=4, SYNC_STAGES=2 and ADDR_W=12. This gives five flag bits, so one table can cover both gating tiers on a timer flag and a peripheral flag, including enabled sources whose flags are not set. The two-stage synchroniser puts the pin and change-group paths at their real latency, so edge polarity and the ignored opposite edge are checked after that delay has passed. Directed tests cover set-versus-clear collisions, take and return ordering, and re-assertion of a pending flag on return.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int unsigned SRC_TMR  = 0;
   localparam int unsigned SRC_EXT  = 1;
   localparam int unsigned SRC_CHG  = 2;
   localparam int unsigned NUM_CORE = 3;

   localparam int unsigned CTRL_GIE  = 0;
   localparam int unsigned CTRL_PEIE = 1;
   localparam int unsigned CTRL_EDGE = 2;
   localparam int unsigned CTRL_W    = 3;

   typedef enum logic [1:0] {
      REG_FLAG = 2'd0,
      REG_EN   = 2'd1,
      REG_CTRL = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < int'(STAGES); s++) st[s] <= '0;
            end else begin
               st[0] <= d_i;
               for (int s = 1; s < int'(STAGES); s++) st[s] <= st[s-1];
            end
         end
         assign q_o = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/irq_event_detect.sv
module irq_event_detect #(
   parameter int unsigned CHG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_i,
   input  logic [CHG_W-1:0] chg_i,
   input  logic             rise_sel_i,
   output logic             ext_evt_o,
   output logic             chg_evt_o
);
   logic             ext_q;
   logic [CHG_W-1:0] chg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q <= 1'b0;
         chg_q <= '0;
      end else begin
         ext_q <= ext_i;
         chg_q <= chg_i;
      end
   end

   assign ext_evt_o = rise_sel_i ? (ext_i & ~ext_q) : (~ext_i & ext_q);
   assign chg_evt_o = |(chg_i ^ chg_q);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   generate
      for (genvar i = 0; i < int'(N); i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_o[i] <= 1'b0;
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (clr_i[i]) flag_o[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
   parameter int unsigned N        = 5,
   parameter int unsigned NUM_CORE = 3
) (
   input  logic [N-1:0] flag_i,
   input  logic [N-1:0] en_i,
   input  logic         gie_i,
   input  logic         peie_i,
   output logic [N-1:0] gated_o,
   output logic         any_o
);
   generate
      for (genvar i = 0; i < int'(N); i++) begin : g_src
         if (i < int'(NUM_CORE)) begin : g_core
            assign gated_o[i] = flag_i[i] & en_i[i] & gie_i;
         end else begin : g_periph
            assign gated_o[i] = flag_i[i] & en_i[i] & gie_i & peie_i;
         end
      end
   endgenerate
   assign any_o = |gated_o;
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_PERIPH  = 4,
   parameter int unsigned CHG_W       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned RESET_VEC   = 0,
   parameter int unsigned IRQ_VEC     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tmr_ovf_i,
   input  logic                       ext_pin_i,
   input  logic [CHG_W-1:0]           chg_in_i,
   input  logic [NUM_PERIPH-1:0]      periph_done_i,
   input  logic                       irq_take_i,
   input  logic                       irq_ret_i,
   input  logic                       cfg_we_i,
   input  logic [1:0]                 cfg_addr_i,
   input  logic [NUM_PERIPH+2:0]      cfg_wdata_i,
   output logic [NUM_PERIPH+2:0]      flag_o,
   output logic [NUM_PERIPH+2:0]      ien_o,
   output logic [CTRL_W-1:0]          ctrl_o,
   output logic                       irq_o,
   output logic [ADDR_W-1:0]          vec_o
);
   localparam int unsigned NSRC = NUM_CORE + NUM_PERIPH;
   localparam logic [ADDR_W-1:0] IRQ_ADDR   = ADDR_W'(IRQ_VEC);
   localparam logic [ADDR_W-1:0] RESET_ADDR = ADDR_W'(RESET_VEC);

   generate
      if (NUM_PERIPH < 1) begin : g_bad_periph
         $error("NUM_PERIPH must be at least 1");
      end
      if (CHG_W < 1) begin : g_bad_chg
         $error("CHG_W must be at least 1");
      end
      if (ADDR_W > 31 || IRQ_VEC >= (1 << ADDR_W) || RESET_VEC >= (1 << ADDR_W)) begin : g_bad_addr
         $error("vector addresses must fit in ADDR_W bits");
      end
      if (IRQ_VEC == RESET_VEC) begin : g_bad_vec
         $error("interrupt and reset vectors must differ");
      end
   endgenerate

   reg_sel_e sel;
   assign sel = reg_sel_e'(cfg_addr_i);

   logic wr_flag, wr_en, wr_ctrl;
   assign wr_flag = cfg_we_i && (sel == REG_FLAG);
   assign wr_en   = cfg_we_i && (sel == REG_EN);
   assign wr_ctrl = cfg_we_i && (sel == REG_CTRL);

   logic [NSRC-1:0] en_q;
   logic            gie_q, peie_q, edge_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         peie_q <= 1'b0;
         edge_q <= 1'b1;
      end else begin
         if (wr_en) en_q <= cfg_wdata_i;
         if (wr_ctrl) begin
            peie_q <= cfg_wdata_i[CTRL_PEIE];
            edge_q <= cfg_wdata_i[CTRL_EDGE];
         end
      end
   end

   logic gie_d;
   always_comb begin
      gie_d = gie_q;
      if (wr_ctrl)    gie_d = cfg_wdata_i[CTRL_GIE];
      if (irq_ret_i)  gie_d = 1'b1;
      if (irq_take_i) gie_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gie_q <= 1'b0;
      else        gie_q <= gie_d;
   end

   logic [CHG_W:0] raw_async, raw_sync;
   assign raw_async = {chg_in_i, ext_pin_i};

   irq_sync #(.W(CHG_W + 1), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_async),
      .q_o   (raw_sync)
   );

   logic ext_evt, chg_evt;
   irq_event_detect #(.CHG_W(CHG_W)) u_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_i      (raw_sync[0]),
      .chg_i      (raw_sync[CHG_W:1]),
      .rise_sel_i (edge_q),
      .ext_evt_o  (ext_evt),
      .chg_evt_o  (chg_evt)
   );

   logic [NSRC-1:0] set_vec, clr_vec;
   assign set_vec = {periph_done_i, chg_evt, ext_evt, tmr_ovf_i};
   assign clr_vec = wr_flag ? cfg_wdata_i : '0;

   logic [NSRC-1:0] flags;
   irq_flag_bank #(.N(NSRC)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (clr_vec),
      .flag_o (flags)
   );

   logic [NSRC-1:0] gated;
   logic            any_req;
   irq_gate #(.N(NSRC), .NUM_CORE(NUM_CORE)) u_gate (
      .flag_i  (flags),
      .en_i    (en_q),
      .gie_i   (gie_q),
      .peie_i  (peie_q),
      .gated_o (gated),
      .any_o   (any_req)
   );

   assign flag_o = flags;
   assign ien_o  = en_q;
   assign ctrl_o = {edge_q, peie_q, gie_q};
   assign irq_o  = any_req;
   assign vec_o  = any_req ? IRQ_ADDR : RESET_ADDR;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
   parameter int unsigned NUM_PERIPH = 4,
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned RESET_VEC  = 0,
   parameter int unsigned IRQ_VEC    = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  tmr_ovf_i,
   input logic                  irq_take_i,
   input logic                  irq_ret_i,
   input logic                  cfg_we_i,
   input logic [1:0]            cfg_addr_i,
   input logic [NUM_PERIPH+2:0] cfg_wdata_i,
   input logic [NUM_PERIPH+2:0] flag_o,
   input logic [NUM_PERIPH+2:0] ien_o,
   input logic [2:0]            ctrl_o,
   input logic                  irq_o,
   input logic [ADDR_W-1:0]     vec_o
);
   localparam int unsigned NSRC = NUM_PERIPH + 3;
   localparam logic [NSRC-1:0] CORE_MASK = NSRC'(7);

   logic [NSRC-1:0] clr_m;
   assign clr_m = (cfg_we_i && cfg_addr_i == 2'd0) ? cfg_wdata_i : '0;

   // R2: a request needs the global enable and an enabled pending flag
   p_irq_needs_gie_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (ctrl_o[0] && ((flag_o & ien_o) != '0)));

   // R3: without the group enable only core sources can request
   p_periph_needs_peie_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ctrl_o[1]) |-> ((flag_o & ien_o & CORE_MASK) != '0));

   // R4: flags never drop without a clear write
   p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(flag_o) & ~$past(clr_m) & ~flag_o) == '0));

   // R5: a timer pulse always leaves its flag set
   p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf_i |=> flag_o[0]);

   // R8: vector tracks the request
   p_vec_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (vec_o == ADDR_W'(IRQ_VEC)));
   p_vec_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> (vec_o == ADDR_W'(RESET_VEC)));

   // R9: take clears and return sets the global enable
   p_take_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take_i |=> !ctrl_o[0]);
   p_ret_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret_i && !irq_take_i) |=> ctrl_o[0]);
endmodule

bind irq_agg_top irq_agg_chk #(
   .NUM_PERIPH (NUM_PERIPH),
   .ADDR_W     (ADDR_W),
   .RESET_VEC  (RESET_VEC),
   .IRQ_VEC    (IRQ_VEC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tmr_ovf_i   (tmr_ovf_i),
   .irq_take_i  (irq_take_i),
   .irq_ret_i   (irq_ret_i),
   .cfg_we_i    (cfg_we_i),
   .cfg_addr_i  (cfg_addr_i),
   .cfg_wdata_i (cfg_wdata_i),
   .flag_o      (flag_o),
   .ien_o       (ien_o),
   .ctrl_o      (ctrl_o),
   .irq_o       (irq_o),
   .vec_o       (vec_o)
);

// File: tb/irq_agg_top_tb.sv
module irq_agg_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NP   = 2;
   localparam int CW   = 4;
   localparam int NS   = NP + 3;
   localparam int AW   = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tmr_ovf = 1'b0;
   logic          ext_pin = 1'b0;
   logic [CW-1:0] chg = '0;
   logic [NP-1:0] pdone = '0;
   logic          take = 1'b0;
   logic          ret = 1'b0;
   logic          we = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [NS-1:0] wdata = '0;
   logic [NS-1:0] flag, ien;
   logic [2:0]    ctrl;
   logic          irq;
   logic [AW-1:0] vec;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_agg_top #(.NUM_PERIPH(NP), .CHG_W(CW), .SYNC_STAGES(2), .ADDR_W(AW),
                 .RESET_VEC(0), .IRQ_VEC(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .tmr_ovf_i(tmr_ovf), .ext_pin_i(ext_pin),
      .chg_in_i(chg), .periph_done_i(pdone), .irq_take_i(take), .irq_ret_i(ret),
      .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
      .flag_o(flag), .ien_o(ien), .ctrl_o(ctrl), .irq_o(irq), .vec_o(vec));

   // {enable[4:0], ctrl[2:0], expected irq}, flags 0 and 3 pending
   localparam logic [NS+3:0] TBL [8] = '{
      {5'b00001, 3'b101, 1'b1},
      {5'b00001, 3'b100, 1'b0},
      {5'b00000, 3'b111, 1'b0},
      {5'b01000, 3'b101, 1'b0},
      {5'b01000, 3'b111, 1'b1},
      {5'b01000, 3'b110, 1'b0},
      {5'b10000, 3'b111, 1'b0},
      {5'b00110, 3'b111, 1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [NS-1:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0; wdata = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      check("R1 flags", 32'(flag), 0);
      check("R1 enables", 32'(ien), 0);
      check("R1 ctrl", 32'(ctrl), 32'h4);
      check("R1 irq", 32'(irq), 0);
      check("R1 vec", 32'(vec), 0);
      rst_n = 1'b1;
      idle(4);

      // R10: timer and peripheral pulses set their bits
      @(negedge clk); tmr_ovf = 1'b1; pdone = 2'b01;
      @(negedge clk); tmr_ovf = 1'b0; pdone = 2'b00;
      check("R10 timer+periph0 flags", 32'(flag), 32'h09);

      // R2 R3: gating table
      for (int k = 0; k < 8; k++) begin
         wr(2'd1, TBL[k][NS+3:4]);
         wr(2'd2, NS'(TBL[k][3:1]));
         check($sformatf("R2/R3 table row %0d irq", k), 32'(irq), 32'(TBL[k][0]));
         check($sformatf("R8 table row %0d vec", k), 32'(vec), TBL[k][0] ? 32'h4 : 32'h0);
      end

      // R4: partial clear
      wr(2'd1, 5'b01001);
      wr(2'd2, 5'b00101);
      check("R4 before clear irq", 32'(irq), 1);
      wr(2'd0, 5'b01000);
      check("R4 partial clear flags", 32'(flag), 32'h01);
      check("R4 irq stays", 32'(irq), 1);
      wr(2'd0, 5'b00001);
      check("R4 full clear flags", 32'(flag), 0);
      check("R4 irq drops", 32'(irq), 0);
      check("R8 vec idle", 32'(vec), 0);

      // R5: set beats clear
      @(negedge clk); tmr_ovf = 1'b1; we = 1'b1; addr = 2'd0; wdata = 5'b00001;
      @(negedge clk); tmr_ovf = 1'b0; we = 1'b0; wdata = '0;
      check("R5 set wins flag0", 32'(flag[0]), 1);
      wr(2'd0, 5'b00001);
      check("R5 later clear", 32'(flag[0]), 0);

      // R10: second peripheral
      @(negedge clk); pdone = 2'b10;
      @(negedge clk); pdone = 2'b00;
      check("R10 periph1 flag", 32'(flag), 32'h10);
      wr(2'd0, 5'b11111);

      // R6: rising edge select
      wr(2'd2, 5'b00100);
      @(negedge clk); ext_pin = 1'b1;
      idle(5);
      check("R6 rising sets", 32'(flag[1]), 1);
      wr(2'd0, 5'b00010);
      @(negedge clk); ext_pin = 1'b0;
      idle(5);
      check("R6 falling ignored", 32'(flag[1]), 0);
      // R6: falling edge select
      wr(2'd2, 5'b00000);
      @(negedge clk); ext_pin = 1'b1;
      idle(5);
      check("R6 rising ignored", 32'(flag[1]), 0);
      @(negedge clk); ext_pin = 1'b0;
      idle(5);
      check("R6 falling sets", 32'(flag[1]), 1);
      wr(2'd0, 5'b11111);

      // R7: change group
      @(negedge clk); chg = 4'b0100;
      idle(5);
      check("R7 change bit2 sets", 32'(flag), 32'h04);
      wr(2'd0, 5'b00100);
      idle(5);
      check("R7 no change stays clear", 32'(flag), 0);
      @(negedge clk); chg = 4'b0101;
      idle(5);
      check("R7 change bit0 sets", 32'(flag), 32'h04);
      wr(2'd0, 5'b11111);

      // R9: take and return
      wr(2'd1, 5'b00001);
      wr(2'd2, 5'b00101);
      @(negedge clk); tmr_ovf = 1'b1;
      @(negedge clk); tmr_ovf = 1'b0;
      check("R9 irq pending", 32'(irq), 1);
      check("R8 vec active", 32'(vec), 32'h4);
      @(negedge clk); take = 1'b1;
      @(negedge clk); take = 1'b0;
      check("R9 take clears gie", 32'(ctrl[0]), 0);
      check("R9 irq masked", 32'(irq), 0);
      check("R4 flag kept in handler", 32'(flag[0]), 1);
      @(negedge clk); ret = 1'b1;
      @(negedge clk); ret = 1'b0;
      check("R9 ret sets gie", 32'(ctrl[0]), 1);
      check("R4 reassert on return", 32'(irq), 1);
      @(negedge clk); take = 1'b1; ret = 1'b1;
      @(negedge clk); take = 1'b0; ret = 1'b0;
      check("R9 take beats ret", 32'(ctrl[0]), 0);
      @(negedge clk); take = 1'b1; we = 1'b1; addr = 2'd2; wdata = 5'b00101;
      @(negedge clk); take = 1'b0; we = 1'b0; wdata = '0;
      check("R9 take beats write", 32'(ctrl[0]), 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule